// File: doc/BRIEF.md
# Watermark FIFO Mailbox Channel

This block carries word messages from a sending agent to a receiving agent through a FIFO that is 32 words deep and 32 bits wide. Both agents reach it through one simple register port. The sender pushes words by writing a push register. The receiver pops them by reading a pop register. A status word reports the fill state, and a programmable fill threshold (the watermark) lets the receiver learn when a whole message has arrived.

A shared sticky event word records fill-state changes and errors. Each event is latched when it happens and stays set until a write-one-to-clear. Each side has its own enable mask, and each side gets its own interrupt line formed from the events it enabled. A typical sender loads a message and then enables the empty event, which it uses as its transmit-complete signal. A typical receiver waits for the full event or the rising-threshold event, then pops words until the FIFO is empty or 32 words have been taken. A flush register empties the FIFO without touching its configuration.

Top module: `mbx_wm_fifo_chan`

## Requirements
- R1: After reset the following hold. The status word reads 0x04 (empty only). The event word reads 0. The watermark reads DEPTH (32). Both interrupt lines are low.
- R2: Words written to offset 0xAC are returned in write order by reads of offset 0xB0. Any read's data appears on bus_rdata in the cycle after the request.
- R3: A write to 0xAC while the FIFO holds DEPTH words is dropped. It sets event bit 6 and status bit 4.
- R4: A read of 0xB0 while the FIFO is empty returns 0 and leaves the FIFO contents unchanged. It sets event bit 7 and status bit 3.
- R5: Status word at 0xB4 has these live bits: bit 0 is set when the fill level is at or above the watermark; bit 1 is full; bit 2 is empty.
- R6: Event word bit 4 is set when "fill level at or above watermark" goes from false to true. Bit 5 is set on the opposite change. The watermark is held at 0xB8.
- R7: Event word bit 2 is set when the level becomes DEPTH. Bit 3 is set when the level becomes zero from a non-zero value. Bit 8 is set when the level leaves zero.
- R8: The event word is read at 0xC8. Writing ones to 0xC4 clears the matching event bits, and bits written as zero keep their value.
- R9: Writing bit 0 set to 0xCC empties the FIFO. It is treated as a level change and raises the matching events. It leaves the watermark and both enable masks unchanged.
- R10: irq_a is high one cycle after any event bit that is enabled in the side-A mask (0xBC) is set. irq_b does the same for the side-B mask (0xC0).
- R11: Unmapped offsets read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register access request, one per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| irq_a | output | 1 | Side-A interrupt (sender) |
| irq_b | output | 1 | Side-B interrupt (receiver) |

## Verification
If the read or write pointer is wrong, the next pop returns the wrong word at once. If the level counter drifts, the status word and the full, empty and threshold events disagree with the number of words pushed, on the very next status read. If the event logic misses a crossing, the sticky event word stays zero where a bit was expected, and the interrupt line stays low one cycle later. A flush that also wipes the configuration shows up as a changed watermark or mask readback immediately after it.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic [7:0] OFS_PUSH  = 8'hAC;
  localparam logic [7:0] OFS_POP   = 8'hB0;
  localparam logic [7:0] OFS_STAT  = 8'hB4;
  localparam logic [7:0] OFS_WMARK = 8'hB8;
  localparam logic [7:0] OFS_ENA   = 8'hBC;
  localparam logic [7:0] OFS_ENB   = 8'hC0;
  localparam logic [7:0] OFS_CLR   = 8'hC4;
  localparam logic [7:0] OFS_EVT   = 8'hC8;
  localparam logic [7:0] OFS_FLUSH = 8'hCC;

  localparam int EV_FULL  = 2;
  localparam int EV_EMPTY = 3;
  localparam int EV_RISE  = 4;
  localparam int EV_FALL  = 5;
  localparam int EV_OVF   = 6;
  localparam int EV_UDF   = 7;
  localparam int EV_NEMP  = 8;
  localparam int EV_W     = 9;
endpackage

// File: rtl/mbx_fifo_store.sv
module mbx_fifo_store #(
  parameter int DEPTH = 32,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic          flush,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] pop_q,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_d,
  output logic          ovf,
  output logic          udf
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, empty, do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign ovf     = push && full;
  assign udf     = pop && empty;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    cnt_d = cnt_q;
    if (flush)        cnt_d = '0;
    else if (do_push) cnt_d = cnt_q + 1'b1;
    else if (do_pop)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
      pop_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (flush) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
      end else begin
        if (do_push) wr_ptr <= nxt(wr_ptr);
        if (do_pop)  rd_ptr <= nxt(rd_ptr);
      end
      if (pop) pop_q <= do_pop ? mem[rd_ptr] : '0;
    end
  end

  // R3: a write while full is dropped
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (push && full && !flush) |=> (cnt_q == CW'(DEPTH)));
  // R4: a read while empty moves nothing and yields zero
  a_r4_empty_pop_hold: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !flush) |=> (cnt_q == '0 && $stable(rd_ptr) && pop_q == '0));
  // R9: flush empties the FIFO
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> (cnt_q == '0));
  a_r2_level_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/mbx_evt_bank.sv
module mbx_evt_bank
  import mbx_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CW-1:0]   cnt_q,
  input  logic [CW-1:0]   cnt_d,
  input  logic            ovf,
  input  logic            udf,
  input  logic            wm_we,
  input  logic            ena_we,
  input  logic            enb_we,
  input  logic            clr_we,
  input  logic [CW-1:0]   wm_bits,
  input  logic [EV_W-1:0] ev_bits,
  output logic [CW-1:0]   wm_q,
  output logic [EV_W-1:0] en_a_q,
  output logic [EV_W-1:0] en_b_q,
  output logic [EV_W-1:0] ev_q,
  output logic            lvl_hit,
  output logic            irq_a,
  output logic            irq_b
);
  logic [CW-1:0]   wm_d;
  logic [EV_W-1:0] set_v, clr_v;
  logic            lvl_new;

  assign wm_d    = wm_we ? wm_bits : wm_q;
  assign lvl_hit = (cnt_q >= wm_q);
  assign lvl_new = (cnt_d >= wm_d);
  assign clr_v   = clr_we ? ev_bits : '0;

  always_comb begin
    set_v           = '0;
    set_v[EV_FULL]  = (cnt_d == CW'(DEPTH)) && (cnt_q != CW'(DEPTH));
    set_v[EV_EMPTY] = (cnt_d == '0) && (cnt_q != '0);
    set_v[EV_RISE]  = lvl_new && !lvl_hit;
    set_v[EV_FALL]  = !lvl_new && lvl_hit;
    set_v[EV_OVF]   = ovf;
    set_v[EV_UDF]   = udf;
    set_v[EV_NEMP]  = (cnt_d != '0) && (cnt_q == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wm_q   <= CW'(DEPTH);
      en_a_q <= '0;
      en_b_q <= '0;
      ev_q   <= '0;
      irq_a  <= 1'b0;
      irq_b  <= 1'b0;
    end else begin
      wm_q  <= wm_d;
      if (ena_we) en_a_q <= ev_bits;
      if (enb_we) en_b_q <= ev_bits;
      ev_q  <= (ev_q & ~clr_v) | set_v;
      irq_a <= |(ev_q & en_a_q);
      irq_b <= |(ev_q & en_b_q);
    end
  end

  // R6: a rising threshold crossing leaves bit 4 set
  a_r6_rise_latched: assert property (@(posedge clk) disable iff (rst)
    (!lvl_hit ##1 (lvl_hit && !$past(clr_we))) |-> ev_q[EV_RISE]);
  // R7: reaching full leaves bit 2 set
  a_r7_full_latched: assert property (@(posedge clk) disable iff (rst)
    ((cnt_q != CW'(DEPTH)) ##1 (cnt_q == CW'(DEPTH) && !$past(clr_we))) |-> ev_q[EV_FULL]);
  // R10: interrupt lines follow enabled events one cycle later
  a_r10_irq_a_follows: assert property (@(posedge clk) disable iff (rst)
    (|(ev_q & en_a_q)) |=> irq_a);
  a_r10_irq_b_quiet: assert property (@(posedge clk) disable iff (rst)
    !(|(ev_q & en_b_q)) |=> !irq_b);
endmodule

// File: rtl/mbx_wm_fifo_chan.sv
module mbx_wm_fifo_chan
  import mbx_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic [7:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_a,
  output logic          irq_b
);
  logic            wr, rd, push, pop, flush;
  logic [DW-1:0]   pop_q, reg_q, reg_d;
  logic            sel_pop_q;
  logic [CW-1:0]   cnt_q, cnt_d, wm_q;
  logic            ovf, udf, lvl_hit;
  logic [EV_W-1:0] en_a_q, en_b_q, ev_q;
  logic [4:0]      stat;

  assign wr    = bus_req && bus_we;
  assign rd    = bus_req && !bus_we;
  assign push  = wr && (bus_addr == OFS_PUSH);
  assign pop   = rd && (bus_addr == OFS_POP);
  assign flush = wr && (bus_addr == OFS_FLUSH) && bus_wdata[0];

  mbx_fifo_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .flush(flush),
    .wdata(bus_wdata), .pop_q(pop_q), .cnt_q(cnt_q), .cnt_d(cnt_d),
    .ovf(ovf), .udf(udf)
  );

  mbx_evt_bank #(.DEPTH(DEPTH)) u_evt (
    .clk(clk), .rst(rst), .cnt_q(cnt_q), .cnt_d(cnt_d), .ovf(ovf), .udf(udf),
    .wm_we(wr && bus_addr == OFS_WMARK),
    .ena_we(wr && bus_addr == OFS_ENA),
    .enb_we(wr && bus_addr == OFS_ENB),
    .clr_we(wr && bus_addr == OFS_CLR),
    .wm_bits(bus_wdata[CW-1:0]), .ev_bits(bus_wdata[EV_W-1:0]),
    .wm_q(wm_q), .en_a_q(en_a_q), .en_b_q(en_b_q), .ev_q(ev_q),
    .lvl_hit(lvl_hit), .irq_a(irq_a), .irq_b(irq_b)
  );

  assign stat = {ev_q[EV_OVF], ev_q[EV_UDF], (cnt_q == '0),
                 (cnt_q == CW'(DEPTH)), lvl_hit};

  always_comb begin
    reg_d = '0;
    unique case (bus_addr)
      OFS_STAT:  reg_d = DW'(stat);
      OFS_WMARK: reg_d = DW'(wm_q);
      OFS_ENA:   reg_d = DW'(en_a_q);
      OFS_ENB:   reg_d = DW'(en_b_q);
      OFS_EVT:   reg_d = DW'(ev_q);
      default:   reg_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q     <= '0;
      sel_pop_q <= 1'b0;
    end else if (rd) begin
      reg_q     <= reg_d;
      sel_pop_q <= pop;
    end
  end

  assign bus_rdata = sel_pop_q ? pop_q : reg_q;

  // R5: full and empty status never coexist with a partial level
  a_r5_stat_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(stat[1] && stat[2]));
endmodule

// File: tb/test_mbx_wm_fifo_chan.sv
`timescale 1ns/1ps
module test_mbx_wm_fifo_chan;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_a, irq_b;
  int          total = 0, bad = 0;
  bit          ended = 0;

  always #2.5 clk = ~clk;

  mbx_wm_fifo_chan i_mbx_wm_fifo_chan (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_a(irq_a), .irq_b(irq_b)
  );

  // vector: {write, offset, data, expected read data}
  localparam logic [72:0] VEC [0:17] = '{
    {1'b0, 8'hB4, 32'h0,   32'h004},  // R5 empty
    {1'b1, 8'hB8, 32'd2,   32'h0},
    {1'b1, 8'hAC, 32'h11,  32'h0},
    {1'b0, 8'hC8, 32'h0,   32'h100},  // R7 not-empty
    {1'b1, 8'hAC, 32'h22,  32'h0},
    {1'b0, 8'hB4, 32'h0,   32'h001},  // R5 at watermark
    {1'b0, 8'hC8, 32'h0,   32'h110},  // R6 rise
    {1'b1, 8'hC4, 32'h100, 32'h0},
    {1'b0, 8'hC8, 32'h0,   32'h010},  // R8 partial clear
    {1'b1, 8'hC4, 32'h1FC, 32'h0},
    {1'b0, 8'hC8, 32'h0,   32'h000},  // R8
    {1'b0, 8'hB0, 32'h0,   32'h11},   // R2
    {1'b0, 8'hC8, 32'h0,   32'h020},  // R6 fall
    {1'b0, 8'hB0, 32'h0,   32'h22},   // R2
    {1'b0, 8'hC8, 32'h0,   32'h028},  // R7 empty
    {1'b0, 8'hB0, 32'h0,   32'h0},    // R4 zero
    {1'b0, 8'hB4, 32'h0,   32'h00C},  // R4 status
    {1'b0, 8'hC8, 32'h0,   32'h0A8}   // R4 event
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_req = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_req = 0;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    rd(8'hB4, v); check("R1 status", v, 32'h4);
    rd(8'hC8, v); check("R1 events", v, 32'h0);
    rd(8'hB8, v); check("R1 watermark", v, 32'd32);
    check("R1 irq_a", {31'd0, irq_a}, 32'h0);
    check("R1 irq_b", {31'd0, irq_b}, 32'h0);

    for (int i = 0; i < 18; i++) begin
      if (VEC[i][72]) wr(VEC[i][71:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][71:64], v);
        check($sformatf("R2/R4/R5/R6/R7/R8 vector %0d", i), v, VEC[i][31:0]);
      end
    end

    // R11 unmapped offset
    wr(8'h00, 32'hFFFFFFFF);
    rd(8'h00, v); check("R11 unmapped read", v, 32'h0);
    rd(8'hC8, v); check("R11 events unchanged", v, 32'h0A8);

    // fill to full, then overflow
    wr(8'hC4, 32'hFFFFFFFF);
    wr(8'hB8, 32'd32);
    for (int i = 0; i < 32; i++) wr(8'hAC, 32'h100 + i);
    rd(8'hB4, v); check("R5 full status", v, 32'h03);
    rd(8'hC8, v); check("R7 full events", v, 32'h114);
    wr(8'hAC, 32'hDEAD);
    rd(8'hB4, v); check("R3 overflow status", v, 32'h13);
    rd(8'hC8, v); check("R3 overflow event", v, 32'h154);
    for (int i = 0; i < 32; i++) begin
      rd(8'hB0, v); check("R2 drain order", v, 32'h100 + i);
    end
    rd(8'hB0, v); check("R3 dropped word absent", v, 32'h0);

    // flush keeps configuration, interrupts per side
    wr(8'hC4, 32'hFFFFFFFF);
    wr(8'hBC, 32'h008);
    wr(8'hC0, 32'h100);
    wr(8'hB8, 32'd5);
    for (int i = 0; i < 3; i++) wr(8'hAC, 32'h50 + i);
    @(negedge clk);
    check("R10 irq_b on not-empty", {31'd0, irq_b}, 32'h1);
    check("R10 irq_a masked", {31'd0, irq_a}, 32'h0);
    wr(8'hCC, 32'h1);
    rd(8'hB4, v); check("R9 flushed status", v, 32'h04);
    rd(8'hB8, v); check("R9 watermark kept", v, 32'd5);
    rd(8'hBC, v); check("R9 side-A mask kept", v, 32'h008);
    rd(8'hC0, v); check("R9 side-B mask kept", v, 32'h100);
    check("R10 irq_a on empty", {31'd0, irq_a}, 32'h1);
    wr(8'hC4, 32'h008);
    @(negedge clk);
    check("R10 irq_a cleared", {31'd0, irq_a}, 32'h0);
    rd(8'hB0, v); check("R9 flushed read zero", v, 32'h0);

    // R1 reset again clears state
    rst = 1; @(negedge clk); rst = 0; @(negedge clk);
    rd(8'hC8, v); check("R1 events after reset", v, 32'h0);
    finish_run();
  end
endmodule